// File: doc/BRIEF.md
# Relative Operand Address Resolver

This block turns the 7-bit source-operand code of a shader instruction, together with a 2-bit index selector, into a register class and an index within that class. It holds three small signed address registers: two offset registers (`a0x`, `a0y`) and a loop counter (`aloop`). When the operand names a constant register, the selected register is added to the constant index. When the operand names an input or a temporary register, the offset is dropped and the register index passes through unchanged.

The two offset registers are loaded by a move-to-address operation. It takes the x and y components of a 24-bit float source (1 sign bit, 7 exponent bits with bias 63, 16 mantissa bits), truncates each toward zero and saturates it to the signed 8-bit range. Each component is written only if its mask bit is set. A loop controller loads the loop counter directly.

Operand resolution is purely combinational. The two write ports are single-cycle strobes that are always accepted, so they have no handshake and no back-pressure. A write takes effect at the next rising clock edge.

Top module: `opaddr_resolver`

## Requirements
- R1: With `idx_sel` = 0 (no offset), a constant operand code k in 0x20..0x7F resolves to class 2 (constant), index k−0x20, and no out-of-range flag.
- R2: Operand codes 0x00..0x0F resolve to class 0 (input) and codes 0x10..0x1F resolve to class 1 (temporary). The index is the low four bits of the code, and the out-of-range flag stays low.
- R3: For a constant operand, `idx_sel` 1 adds `a0x`, 2 adds `a0y` and 3 adds `aloop` to the constant index. For example, c8 (code 0x28) with `a0y` = 3 resolves to index 11.
- R4: For input and temporary operands, the selected register is treated as zero whatever the value of `idx_sel`.
- R5: A move-to-address write converts each written float component to an integer by truncating toward zero. A zero or subnormal exponent (field 0) gives 0. The new value is used for resolution from the cycle after the write edge.
- R6: `mova_mask` bit 0 enables the write of `a0x` from `mova_x`, and bit 1 enables the write of `a0y` from `mova_y`. A component whose mask bit is clear keeps its value.
- R7: `a0x` and `a0y` are signed, and a negative value lowers the resolved constant index.
- R8: Conversions whose value lies outside −128..127 saturate to −128 or 127. An exponent field of 127 (infinity) saturates according to its sign.
- R9: If the offset constant index falls outside 0..95, `res_oor` is 1, `res_index` is 0 and the class stays constant.
- R10: While `rst_n` is low, all three address registers are cleared to zero.
- R11: `loop_wr` loads `loop_val` (signed 8-bit) into `aloop` at the clock edge. This write is independent of a move-to-address write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_code | input | 7 | Source operand code |
| idx_sel | input | 2 | Index selector: 0 none, 1 a0x, 2 a0y, 3 aloop |
| res_class | output | 2 | Resolved class: 0 input, 1 temporary, 2 constant |
| res_index | output | 7 | Index within the resolved class |
| res_oor | output | 1 | Offset constant index out of range |
| mova_en | input | 1 | Move-to-address write strobe |
| mova_mask | input | 2 | Component enables: bit 0 x, bit 1 y |
| mova_x | input | 24 | Float source for a0x |
| mova_y | input | 24 | Float source for a0y |
| loop_wr | input | 1 | Loop counter write strobe |
| loop_val | input | 8 | Signed loop counter value |

## Verification
Resolution has no register on its path, so it is due in the same cycle as its operand inputs. The bench applies the operand, waits a short settle time and then samples, away from any edge. A register write lands on the edge that captures the strobe, so its effect on resolution is due one cycle later. Each table row therefore drives its write and operand at a falling edge, lets one rising edge pass, drops the strobes and then samples. Reset clearing is checked in the cycle after reset is applied, through resolution of c8 under each selector.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;
  localparam int OP_W       = 7;
  localparam int AREG_W     = 8;
  localparam int FEXP_W     = 7;
  localparam int FMAN_W     = 16;
  localparam int FLT_W      = 1 + FEXP_W + FMAN_W;
  localparam int CONST_BASE = 32;
  localparam int CONST_N    = 96;
  localparam int NCOMP      = 2;

  typedef enum logic [1:0] {
    RC_INPUT = 2'd0,
    RC_TEMP  = 2'd1,
    RC_CONST = 2'd2
  } rclass_e;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_AX   = 2'd1,
    SEL_AY   = 2'd2,
    SEL_LOOP = 2'd3
  } isel_e;
endpackage

// File: rtl/opaddr_f2i.sv
module opaddr_f2i #(
  parameter int EXP_W = 7,
  parameter int MAN_W = 16,
  parameter int OUT_W = 8
) (
  input  logic [EXP_W+MAN_W:0] flt,
  output logic [OUT_W-1:0]     ival
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] BIAS_E = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] SAT_E  = EXP_W'(BIAS + OUT_W - 1);
  localparam logic [EXP_W-1:0] TOP_SH = EXP_W'(OUT_W - 2);

  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] man;
  logic [EXP_W-1:0] sh;
  logic [OUT_W-2:0] frac_top;
  logic [OUT_W-2:0] mag;

  assign sgn      = flt[EXP_W+MAN_W];
  assign ex       = flt[EXP_W+MAN_W-1:MAN_W];
  assign man      = flt[MAN_W-1:0];
  assign sh       = ex - BIAS_E;
  assign frac_top = {1'b1, man[MAN_W-1 -: OUT_W-2]};

  always_comb begin
    mag = frac_top >> (TOP_SH - sh);
    if (ex < BIAS_E) begin
      ival = '0;
    end else if (ex >= SAT_E) begin
      ival = sgn ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}};
    end else begin
      ival = sgn ? (~{1'b0, mag} + 1'b1) : {1'b0, mag};
    end
  end
endmodule

// File: rtl/opaddr_regs.sv
module opaddr_regs
  import opaddr_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               mova_en,
  input  logic [NCOMP-1:0]                   mova_mask,
  input  logic [NCOMP-1:0][FLT_W-1:0]        mova_src,
  input  logic                               loop_wr,
  input  logic [AREG_W-1:0]                  loop_val,
  output logic [NCOMP-1:0][AREG_W-1:0]       areg,
  output logic [AREG_W-1:0]                  aloop
);
  for (genvar k = 0; k < NCOMP; k++) begin : g_comp
    logic [AREG_W-1:0] conv;

    opaddr_f2i #(
      .EXP_W(FEXP_W),
      .MAN_W(FMAN_W),
      .OUT_W(AREG_W)
    ) u_f2i (
      .flt (mova_src[k]),
      .ival(conv)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        areg[k] <= '0;
      end else if (mova_en && mova_mask[k]) begin
        areg[k] <= conv;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aloop <= '0;
    end else if (loop_wr) begin
      aloop <= loop_val;
    end
  end
endmodule

// File: rtl/opaddr_map.sv
module opaddr_map
  import opaddr_pkg::*;
(
  input  logic [OP_W-1:0]   code,
  input  logic [1:0]        sel,
  input  logic [AREG_W-1:0] ax,
  input  logic [AREG_W-1:0] ay,
  input  logic [AREG_W-1:0] al,
  output logic [1:0]        cls,
  output logic [OP_W-1:0]   idx,
  output logic              oor
);
  localparam int SUM_W = OP_W + 2;
  localparam logic [SUM_W-1:0] LAST_C = SUM_W'(CONST_N - 1);
  localparam logic [OP_W-1:0]  BASE_C = OP_W'(CONST_BASE);

  logic [AREG_W-1:0] off;
  logic [OP_W-1:0]   base;
  logic [SUM_W-1:0]  sum;
  logic              is_const;

  assign is_const = (code >= BASE_C);
  assign base     = code - BASE_C;

  always_comb begin
    case (isel_e'(sel))
      SEL_AX:   off = ax;
      SEL_AY:   off = ay;
      SEL_LOOP: off = al;
      default:  off = '0;
    endcase
    sum = {2'b00, base} + {{(SUM_W-AREG_W){off[AREG_W-1]}}, off};
  end

  always_comb begin
    if (is_const) begin
      cls = RC_CONST;
      oor = sum[SUM_W-1] || (sum > LAST_C);
      idx = oor ? '0 : sum[OP_W-1:0];
    end else begin
      cls = code[4] ? RC_TEMP : RC_INPUT;
      oor = 1'b0;
      idx = {{(OP_W-4){1'b0}}, code[3:0]};
    end
  end
endmodule

// File: rtl/opaddr_resolver.sv
module opaddr_resolver
  import opaddr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [6:0]  src_code,
  input  logic [1:0]  idx_sel,
  output logic [1:0]  res_class,
  output logic [6:0]  res_index,
  output logic        res_oor,
  input  logic        mova_en,
  input  logic [1:0]  mova_mask,
  input  logic [23:0] mova_x,
  input  logic [23:0] mova_y,
  input  logic        loop_wr,
  input  logic [7:0]  loop_val
);
  logic [NCOMP-1:0][FLT_W-1:0]  src_pair;
  logic [NCOMP-1:0][AREG_W-1:0] areg;
  logic [AREG_W-1:0]            a0x;
  logic [AREG_W-1:0]            a0y;
  logic [AREG_W-1:0]            aloop;

  assign src_pair = {mova_y, mova_x};
  assign a0x      = areg[0];
  assign a0y      = areg[1];

  opaddr_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .mova_en  (mova_en),
    .mova_mask(mova_mask),
    .mova_src (src_pair),
    .loop_wr  (loop_wr),
    .loop_val (loop_val),
    .areg     (areg),
    .aloop    (aloop)
  );

  opaddr_map u_map (
    .code(src_code),
    .sel (idx_sel),
    .ax  (a0x),
    .ay  (a0y),
    .al  (aloop),
    .cls (res_class),
    .idx (res_index),
    .oor (res_oor)
  );
endmodule

// File: rtl/opaddr_resolver_chk.sv
module opaddr_resolver_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] src_code,
  input logic [1:0] idx_sel,
  input logic [1:0] res_class,
  input logic [6:0] res_index,
  input logic       res_oor,
  input logic       mova_en,
  input logic [1:0] mova_mask,
  input logic       loop_wr,
  input logic [7:0] loop_val,
  input logic [7:0] a0x,
  input logic [7:0] a0y,
  input logic [7:0] aloop
);
  AST_CLASS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    res_class != 2'd3); // R2

  AST_OOR_ZERO_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    res_oor |-> (res_index == 7'd0 && res_class == 2'd2)); // R9

  AST_NONCONST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (src_code < 7'h20) |-> (!res_oor && res_index == {3'b000, src_code[3:0]})); // R4

  AST_NO_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_sel == 2'd0 && src_code >= 7'h20) |-> (!res_oor && res_index == src_code - 7'h20)); // R1

  AST_X_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(mova_en && mova_mask[0]) |=> $stable(a0x)); // R6

  AST_Y_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(mova_en && mova_mask[1]) |=> $stable(a0y)); // R6

  AST_LOOP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    loop_wr |=> (aloop == $past(loop_val))); // R11

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (a0x == 8'd0 && a0y == 8'd0 && aloop == 8'd0)); // R10
endmodule

bind opaddr_resolver opaddr_resolver_chk u_chk (.*);

// File: tb/opaddr_resolver_bench.sv
module opaddr_resolver_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  mw;
    logic [23:0] xf;
    logic [23:0] yf;
    logic        alw;
    logic [7:0]  alv;
    logic [6:0]  op;
    logic [1:0]  sel;
    logic [1:0]  cls;
    logic [6:0]  idx;
    logic        oor;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t TBL [NV] = '{
    '{2'b01, 24'h408000, 24'h000000, 1'b0, 8'h00, 7'h28, 2'd1, 2'd2, 7'd11, 1'b0, 4'd3},  // R3 a0x=3
    '{2'b10, 24'h414000, 24'h408000, 1'b0, 8'h00, 7'h28, 2'd2, 2'd2, 7'd11, 1'b0, 4'd3},  // R3 c8+a0y(3)=c11
    '{2'b00, 24'h414000, 24'h414000, 1'b0, 8'h00, 7'h28, 2'd1, 2'd2, 7'd11, 1'b0, 4'd6},  // R6 a0x kept 3
    '{2'b11, 24'h40E000, 24'hC04000, 1'b0, 8'h00, 7'h2A, 2'd2, 2'd2, 7'd8,  1'b0, 4'd7},  // R7 a0y=-2
    '{2'b00, 24'h000000, 24'h000000, 1'b0, 8'h00, 7'h2A, 2'd1, 2'd2, 7'd13, 1'b0, 4'd5},  // R5 3.75->3
    '{2'b01, 24'h3E8000, 24'h000000, 1'b0, 8'h00, 7'h28, 2'd1, 2'd2, 7'd8,  1'b0, 4'd5},  // R5 0.75->0
    '{2'b00, 24'h000000, 24'h000000, 1'b1, 8'h14, 7'h20, 2'd3, 2'd2, 7'd20, 1'b0, 4'd11}, // R11 aloop=20
    '{2'b11, 24'h3F0000, 24'hBF0000, 1'b0, 8'h00, 7'h7E, 2'd1, 2'd2, 7'd95, 1'b0, 4'd9},  // R9 c94+1
    '{2'b00, 24'h000000, 24'h000000, 1'b0, 8'h00, 7'h7F, 2'd1, 2'd2, 7'd0,  1'b1, 4'd9},  // R9 c95+1
    '{2'b00, 24'h000000, 24'h000000, 1'b0, 8'h00, 7'h20, 2'd2, 2'd2, 7'd0,  1'b1, 4'd9},  // R9 c0-1
    '{2'b00, 24'h000000, 24'h000000, 1'b0, 8'h00, 7'h21, 2'd2, 2'd2, 7'd0,  1'b0, 4'd9},  // R9 c1-1
    '{2'b01, 24'h45FE00, 24'h000000, 1'b0, 8'h00, 7'h20, 2'd1, 2'd2, 7'd0,  1'b1, 4'd5},  // R5 127.5->127
    '{2'b01, 24'h469000, 24'h000000, 1'b0, 8'h00, 7'h7F, 2'd1, 2'd2, 7'd0,  1'b1, 4'd8},  // R8 200 sat
    '{2'b10, 24'h000000, 24'hC72C00, 1'b0, 8'h00, 7'h7F, 2'd2, 2'd2, 7'd0,  1'b1, 4'd8},  // R8 -300 sat
    '{2'b01, 24'h7F0000, 24'h000000, 1'b0, 8'h00, 7'h7F, 2'd1, 2'd2, 7'd0,  1'b1, 4'd8},  // R8 +inf
    '{2'b11, 24'h000000, 24'h414000, 1'b0, 8'h00, 7'h20, 2'd1, 2'd2, 7'd0,  1'b0, 4'd5},  // R5 zero->0
    '{2'b00, 24'h000000, 24'h000000, 1'b0, 8'h00, 7'h20, 2'd2, 2'd2, 7'd5,  1'b0, 4'd5},  // R5 5.0->5
    '{2'b00, 24'h000000, 24'h000000, 1'b0, 8'h00, 7'h05, 2'd2, 2'd0, 7'd5,  1'b0, 4'd4},  // R4 input
    '{2'b00, 24'h000000, 24'h000000, 1'b0, 8'h00, 7'h13, 2'd3, 2'd1, 7'd3,  1'b0, 4'd4},  // R4 temp
    '{2'b00, 24'h000000, 24'h000000, 1'b0, 8'h00, 7'h1F, 2'd1, 2'd1, 7'd15, 1'b0, 4'd2},  // R2 r15
    '{2'b00, 24'h000000, 24'h000000, 1'b0, 8'h00, 7'h0F, 2'd0, 2'd0, 7'd15, 1'b0, 4'd2},  // R2 v15
    '{2'b00, 24'h000000, 24'h000000, 1'b0, 8'h00, 7'h7F, 2'd0, 2'd2, 7'd95, 1'b0, 4'd1},  // R1 c95
    '{2'b00, 24'h000000, 24'h000000, 1'b0, 8'h00, 7'h28, 2'd0, 2'd2, 7'd8,  1'b0, 4'd1},  // R1 c8
    '{2'b00, 24'h000000, 24'h000000, 1'b1, 8'hF6, 7'h2A, 2'd3, 2'd2, 7'd0,  1'b0, 4'd11}, // R11 aloop=-10
    '{2'b01, 24'h3F0000, 24'h000000, 1'b1, 8'h02, 7'h20, 2'd3, 2'd2, 7'd2,  1'b0, 4'd11}, // R11 both writes
    '{2'b00, 24'h000000, 24'h000000, 1'b0, 8'h00, 7'h20, 2'd1, 2'd2, 7'd1,  1'b0, 4'd11}  // R11 a0x=1
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  src_code = '0;
  logic [1:0]  idx_sel = '0;
  logic [1:0]  res_class;
  logic [6:0]  res_index;
  logic        res_oor;
  logic        mova_en = 1'b0;
  logic [1:0]  mova_mask = '0;
  logic [23:0] mova_x = '0;
  logic [23:0] mova_y = '0;
  logic        loop_wr = 1'b0;
  logic [7:0]  loop_val = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opaddr_resolver u_opaddr_resolver (
    .clk(clk), .rst_n(rst_n), .src_code(src_code), .idx_sel(idx_sel),
    .res_class(res_class), .res_index(res_index), .res_oor(res_oor),
    .mova_en(mova_en), .mova_mask(mova_mask), .mova_x(mova_x), .mova_y(mova_y),
    .loop_wr(loop_wr), .loop_val(loop_val)
  );

  task automatic expect_res(input logic [1:0] ec, input logic [6:0] ei,
                            input logic eo, input int req);
    checks++;
    if (res_class !== ec || res_index !== ei || res_oor !== eo) begin
      errors++;
      $display("FAIL R%0d: actual class=%0d index=%0d oor=%0b expected class=%0d index=%0d oor=%0b",
               req, res_class, res_index, res_oor, ec, ei, eo);
    end
  endtask

  task automatic probe(input logic [6:0] op, input logic [1:0] sel);
    src_code = op;
    idx_sel  = sel;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: actual still running, expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: registers start cleared, so every selector leaves c8 at index 8
    for (int s = 0; s < 4; s++) begin
      probe(7'h28, 2'(s));
      expect_res(2'd2, 7'd8, 1'b0, 10);
    end

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mova_en   = (TBL[i].mw != 2'b00);
      mova_mask = TBL[i].mw;
      mova_x    = TBL[i].xf;
      mova_y    = TBL[i].yf;
      loop_wr   = TBL[i].alw;
      loop_val  = TBL[i].alv;
      src_code  = TBL[i].op;
      idx_sel   = TBL[i].sel;
      @(posedge clk);
      #1;
      mova_en = 1'b0;
      loop_wr = 1'b0;
      #1;
      expect_res(TBL[i].cls, TBL[i].idx, TBL[i].oor, int'(TBL[i].req));
    end

    // R10: reset in mid-run clears nonzero a0x and aloop
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    probe(7'h28, 2'd1);
    expect_res(2'd2, 7'd8, 1'b0, 10);
    probe(7'h28, 2'd3);
    expect_res(2'd2, 7'd8, 1'b0, 10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule